// File: doc/BRIEF.md
# Masked Debug Bus Comparator

This block watches a processor bus and reports when an access meets a condition that software has programmed. Each channel holds a 16-bit address to compare. Channel 0 can also compare the 16-bit data bus against a stored value. A per-bit mask selects which data bits are compared. A channel can also require a given transfer direction (read or write) and a given access size (byte or word) before it reports a hit.

Each channel runs in one of two modes. In forced mode it emits a one-cycle pulse right after the qualifying access completes. In tagged mode it marks an opcode fetch from the programmed address. It pulses only when the core later reports that it executed the instruction carrying the same tag. A pipeline flush that comes first discards the mark.

Settings are held in byte-wide registers. Software can change them only while the comparator is disarmed and the register window select is zero. Debug logic uses the pulses on `match_o` to drive its sequencing.

Top module: `bus_match_unit`

## Requirements
- R1: After reset every setting register reads 0 (both data mask bytes included, so no data bit is compared) and `match_o` is 0.
- R2: A forced-mode channel whose address equals the bus address of an access with `bus_valid_i` high drives its `match_o` bit high for the one cycle after that access, and keeps it low for any other address.
- R3: Channel 0 compares bus data against its data value wherever the mask bit is 1 and ignores bits whose mask bit is 0. Other channels hold no data registers: their data and mask offsets read 0.
- R4: On a byte access (`bus_byte_i`=1), channel 0 compares only one data lane: bits 15:8 when bus address bit 0 is 0, bits 7:0 when it is 1. Mask bits of the other lane have no effect. A word access compares all 16 bits.
- R5: With the direction qualifier enabled (control bit 1), a channel hits only when `bus_rnw_i` equals control bit 2 (1 = read).
- R6: With the size qualifier enabled (control bit 3), a channel hits only when `bus_byte_i` equals control bit 4 (1 = byte).
- R7: With control bit 0 set (tagged mode), a hit on an opcode fetch (`bus_fetch_i`=1) records `bus_tag_i` and produces no pulse. The pulse comes in the cycle after `exec_valid_i` arrives with an equal `exec_tag_i`, and the mark is then consumed. Data is not compared in tagged mode. A hit on an access that is not a fetch records nothing.
- R8: `flush_i` discards every pending tagged mark. If a flush and a matching execute strobe arrive in the same cycle, the flush wins and no pulse is produced.
- R9: Register writes take effect only when `arm_i` is 0 and `win_sel_i` is 0. Reads return stored values when `win_sel_i` is 0 and return 0 otherwise.
- R10: While `arm_i` is 0, no channel pulses and every pending tagged mark is dropped.
- R11: Register address = {channel, offset[2:0]}. The offsets are: 0 control (bits 4:0), 1 address 15:8, 2 address 7:0, 3 data 15:8, 4 data 7:0, 5 mask 15:8, 6 mask 7:0. Any offset not listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enables matching and blocks register writes |
| win_sel_i | input | 2 | Register window select; access allowed only at 0 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RA_W (5) | Register address {channel, offset} |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| bus_valid_i | input | 1 | A bus access completes this cycle |
| bus_addr_i | input | 16 | Access address |
| bus_data_i | input | 16 | Access data |
| bus_rnw_i | input | 1 | 1 = read, 0 = write |
| bus_byte_i | input | 1 | 1 = byte access, 0 = word |
| bus_fetch_i | input | 1 | Access is an opcode fetch |
| bus_tag_i | input | TAG_W (4) | Tag attached to the fetch |
| exec_valid_i | input | 1 | An instruction executes this cycle |
| exec_tag_i | input | TAG_W (4) | Tag of the executing instruction |
| flush_i | input | 1 | Pipeline flush |
| match_o | output | NUM_CH (3) | One-cycle match pulse per channel |

## Verification
Address compares are run at the programmed address and at a neighbour one LSB away. Data compares use a partial mask and a full mask with one byte altered, to show that the mask separates compared bits from ignored ones. Byte accesses at even and odd addresses, and a word access with the same bytes, show which lane is selected. Tagged runs compare a wrong tag against the right tag, a repeated execute (the mark is consumed), a non-fetch hit, a flush before the execute, a flush in the same cycle as the execute, and a disarm between mark and execute.

// File: rtl/bus_match_pkg.sv
package bus_match_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_CTRL    = 3'd0;
  localparam logic [OFF_W-1:0] OFF_ADDR_HI = 3'd1;
  localparam logic [OFF_W-1:0] OFF_ADDR_LO = 3'd2;
  localparam logic [OFF_W-1:0] OFF_DATA_HI = 3'd3;
  localparam logic [OFF_W-1:0] OFF_DATA_LO = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MASK_HI = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MASK_LO = 3'd6;

  typedef struct packed {
    logic size_byte;
    logic size_en;
    logic dir_read;
    logic dir_en;
    logic tag_mode;
  } ch_ctrl_t;

  localparam int CTRL_W = $bits(ch_ctrl_t);
endpackage

// File: rtl/bus_match_regs.sv
module bus_match_regs
  import bus_match_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  localparam int RA_W  = CH_W + OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         arm_i,
  input  logic [1:0]                   win_sel_i,
  input  logic                         reg_we_i,
  input  logic [RA_W-1:0]              reg_addr_i,
  input  logic [7:0]                   reg_wdata_i,
  output logic [7:0]                   reg_rdata_o,
  output ch_ctrl_t [NUM_CH-1:0]        ctrl_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0] cmp_addr_o,
  output logic [DATA_W-1:0]            cmp_data_o,
  output logic [DATA_W-1:0]            cmp_mask_o
);
  logic             win_open;
  logic             wr_ok;
  logic [CH_W-1:0]  sel_ch;
  logic [OFF_W-1:0] sel_off;

  assign win_open = (win_sel_i == 2'b00);
  assign wr_ok    = reg_we_i && win_open && !arm_i;
  assign sel_ch   = reg_addr_i[RA_W-1:OFF_W];
  assign sel_off  = reg_addr_i[OFF_W-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_ch;
    assign hit_ch = wr_ok && (sel_ch == CH_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[i]     <= '0;
        cmp_addr_o[i] <= '0;
      end else if (hit_ch) begin
        case (sel_off)
          OFF_CTRL:    ctrl_o[i]           <= ch_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
          OFF_ADDR_HI: cmp_addr_o[i][15:8] <= reg_wdata_i;
          OFF_ADDR_LO: cmp_addr_o[i][7:0]  <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  // data value and mask exist for channel 0 only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_data_o <= '0;
      cmp_mask_o <= '0;
    end else if (wr_ok && sel_ch == '0) begin
      case (sel_off)
        OFF_DATA_HI: cmp_data_o[15:8] <= reg_wdata_i;
        OFF_DATA_LO: cmp_data_o[7:0]  <= reg_wdata_i;
        OFF_MASK_HI: cmp_mask_o[15:8] <= reg_wdata_i;
        OFF_MASK_LO: cmp_mask_o[7:0]  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (win_open) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (sel_ch == CH_W'(i)) begin
          case (sel_off)
            OFF_CTRL:    reg_rdata_o = 8'(ctrl_o[i]);
            OFF_ADDR_HI: reg_rdata_o = cmp_addr_o[i][15:8];
            OFF_ADDR_LO: reg_rdata_o = cmp_addr_o[i][7:0];
            default: ;
          endcase
        end
      end
      if (sel_ch == '0) begin
        case (sel_off)
          OFF_DATA_HI: reg_rdata_o = cmp_data_o[15:8];
          OFF_DATA_LO: reg_rdata_o = cmp_data_o[7:0];
          OFF_MASK_HI: reg_rdata_o = cmp_mask_o[15:8];
          OFF_MASK_LO: reg_rdata_o = cmp_mask_o[7:0];
          default: ;
        endcase
      end
    end
  end

  p_armed_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> ($stable(ctrl_o) && $stable(cmp_addr_o) && $stable(cmp_data_o) && $stable(cmp_mask_o)));

  p_window_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_sel_i != 2'b00) |=> ($stable(ctrl_o) && $stable(cmp_addr_o) && $stable(cmp_mask_o)));
endmodule

// File: rtl/bus_match_chan.sv
module bus_match_chan
  import bus_match_pkg::*;
#(
  parameter bit HAS_DATA = 1'b0,
  parameter int TAG_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  ch_ctrl_t          ctrl_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [DATA_W-1:0] cmp_data_i,
  input  logic [DATA_W-1:0] cmp_mask_i,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_rnw_i,
  input  logic              bus_byte_i,
  input  logic              bus_fetch_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic              exec_valid_i,
  input  logic [TAG_W-1:0]  exec_tag_i,
  input  logic              flush_i,
  output logic              match_o
);
  logic             addr_ok, dir_ok, size_ok, data_ok, hit;
  logic             fire_forced, fire_tag, tag_set;
  logic             pend_q;
  logic [TAG_W-1:0] tag_q;

  assign addr_ok = (bus_addr_i == cmp_addr_i);
  assign dir_ok  = !ctrl_i.dir_en  || (bus_rnw_i  == ctrl_i.dir_read);
  assign size_ok = !ctrl_i.size_en || (bus_byte_i == ctrl_i.size_byte);

  if (HAS_DATA) begin : g_data
    logic [DATA_W-1:0] lane_mask;
    always_comb begin
      if (!bus_byte_i)       lane_mask = cmp_mask_i;
      else if (bus_addr_i[0]) lane_mask = {8'h00, cmp_mask_i[7:0]};
      else                   lane_mask = {cmp_mask_i[15:8], 8'h00};
    end
    assign data_ok = ctrl_i.tag_mode || (((bus_data_i ^ cmp_data_i) & lane_mask) == '0);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{cmp_data_i, cmp_mask_i, bus_data_i};
    assign data_ok = 1'b1;
  end

  assign hit         = bus_valid_i && addr_ok && dir_ok && size_ok && data_ok;
  assign fire_forced = arm_i && hit && !ctrl_i.tag_mode;
  assign tag_set     = arm_i && hit && ctrl_i.tag_mode && bus_fetch_i;
  assign fire_tag    = arm_i && pend_q && exec_valid_i && (exec_tag_i == tag_q) && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else if (flush_i || !arm_i) begin
      pend_q <= 1'b0;
    end else if (tag_set) begin
      pend_q <= 1'b1;
      tag_q  <= bus_tag_i;
    end else if (fire_tag) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= 1'b0;
    else         match_o <= fire_forced || fire_tag;
  end

  p_forced_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && bus_valid_i && addr_ok && dir_ok && size_ok && data_ok && !ctrl_i.tag_mode) |=> match_o);

  p_tag_needs_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(fire_forced)) |-> $past(exec_valid_i && pend_q && !flush_i));

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pend_q);

  p_disarm_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (!match_o && !pend_q));
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bus_match_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int TAG_W  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W  = CH_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        win_sel_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_rnw_i,
  input  logic              bus_byte_i,
  input  logic              bus_fetch_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic              exec_valid_i,
  input  logic [TAG_W-1:0]  exec_tag_i,
  input  logic              flush_i,
  output logic [NUM_CH-1:0] match_o
);
  ch_ctrl_t [NUM_CH-1:0]         ctrl;
  logic [NUM_CH-1:0][ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0]             cmp_data;
  logic [DATA_W-1:0]             cmp_mask;

  bus_match_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_regs (
    .clk_i, .rst_ni, .arm_i, .win_sel_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o,
    .ctrl_o     (ctrl),
    .cmp_addr_o (cmp_addr),
    .cmp_data_o (cmp_data),
    .cmp_mask_o (cmp_mask)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    bus_match_chan #(.HAS_DATA(i == 0), .TAG_W(TAG_W)) i_chan (
      .clk_i, .rst_ni, .arm_i,
      .ctrl_i       (ctrl[i]),
      .cmp_addr_i   (cmp_addr[i]),
      .cmp_data_i   (cmp_data),
      .cmp_mask_i   (cmp_mask),
      .bus_valid_i, .bus_addr_i, .bus_data_i, .bus_rnw_i, .bus_byte_i,
      .bus_fetch_i, .bus_tag_i, .exec_valid_i, .exec_tag_i, .flush_i,
      .match_o      (match_o[i])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (match_o == '0));
endmodule

// File: tb/test_bus_match_unit.sv
`timescale 1ns/1ps
module test_bus_match_unit;
  localparam int NUM_CH = 3;
  localparam int TAG_W  = 4;
  localparam int CH_W   = 2;
  localparam int RA_W   = CH_W + 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              arm = 1'b0;
  logic [1:0]        win_sel = '0;
  logic              reg_we = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              bus_valid = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic [15:0]       bus_data = '0;
  logic              bus_rnw = 1'b0;
  logic              bus_byte = 1'b0;
  logic              bus_fetch = 1'b0;
  logic [TAG_W-1:0]  bus_tag = '0;
  logic              exec_valid = 1'b0;
  logic [TAG_W-1:0]  exec_tag = '0;
  logic              flush = 1'b0;
  logic [NUM_CH-1:0] match;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bus_match_unit #(.NUM_CH(NUM_CH), .TAG_W(TAG_W)) i_bus_match_unit (
    .clk_i(clk), .rst_ni, .arm_i(arm), .win_sel_i(win_sel),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .bus_valid_i(bus_valid), .bus_addr_i(bus_addr), .bus_data_i(bus_data),
    .bus_rnw_i(bus_rnw), .bus_byte_i(bus_byte), .bus_fetch_i(bus_fetch),
    .bus_tag_i(bus_tag), .exec_valid_i(exec_valid), .exec_tag_i(exec_tag),
    .flush_i(flush), .match_o(match)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int off, int val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RA_W'((ch << 3) | off); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, int off, int exp, string req);
    @(negedge clk);
    reg_addr = RA_W'((ch << 3) | off);
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic acc(int a, int d, bit rnw, bit byt, bit fetch, int tag, int exp, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'(a); bus_data = 16'(d);
    bus_rnw = rnw; bus_byte = byt; bus_fetch = fetch; bus_tag = TAG_W'(tag);
    @(negedge clk);
    bus_valid = 1'b0; bus_fetch = 1'b0;
    chk(req, int'(match), exp);
    @(negedge clk);
    chk({req, " one-cycle"}, int'(match), 0);
  endtask

  task automatic ex(int tag, bit fl, int exp, string req);
    @(negedge clk);
    exec_valid = 1'b1; exec_tag = TAG_W'(tag); flush = fl;
    @(negedge clk);
    exec_valid = 1'b0; flush = 1'b0;
    chk(req, int'(match), exp);
  endtask

  task automatic set_arm(bit v);
    @(negedge clk);
    arm = v;
  endtask

  task automatic t_reset;
    chk("R1 match", int'(match), 0);
    rd(0, 0, 0, "R1 ctrl0");
    rd(0, 5, 0, "R1 mask hi");
    rd(0, 6, 0, "R1 mask lo");
    rd(2, 1, 0, "R1 addr2 hi");
  endtask

  task automatic t_addr;
    wr(1, 1, 8'h12); wr(1, 2, 8'h34);
    rd(1, 1, 8'h12, "R11 addr hi readback");
    rd(1, 2, 8'h34, "R11 addr lo readback");
    set_arm(1);
    acc(16'h1234, 0, 1, 0, 0, 0, 3'b010, "R2 address hit");
    acc(16'h1235, 0, 1, 0, 0, 0, 3'b000, "R2 address miss");
    set_arm(0);
  endtask

  task automatic t_data;
    wr(0, 1, 8'h20); wr(0, 2, 8'h00);
    wr(0, 3, 8'hA5); wr(0, 4, 8'h5A);
    wr(0, 5, 8'hFF); wr(0, 6, 8'h00);
    set_arm(1);
    acc(16'h2000, 16'hA5FF, 1, 0, 0, 0, 3'b001, "R3 masked-off low byte ignored");
    acc(16'h2000, 16'h005A, 1, 0, 0, 0, 3'b000, "R3 compared high byte differs");
    set_arm(0);
    wr(0, 5, 8'h00);
    set_arm(1);
    acc(16'h2000, 16'h1234, 0, 0, 0, 0, 3'b001, "R3 zero mask matches any data");
    set_arm(0);
    rd(1, 3, 0, "R3 channel 1 has no data reg");
    rd(2, 5, 0, "R3 channel 2 has no mask reg");
  endtask

  task automatic t_lane;
    wr(0, 5, 8'hFF); wr(0, 6, 8'hFF);
    set_arm(1);
    acc(16'h2000, 16'hA500, 1, 1, 0, 0, 3'b001, "R4 even byte uses high lane");
    acc(16'h2000, 16'hA500, 1, 0, 0, 0, 3'b000, "R4 word compares both lanes");
    set_arm(0);
    wr(0, 2, 8'h01);
    set_arm(1);
    acc(16'h2001, 16'h005A, 1, 1, 0, 0, 3'b001, "R4 odd byte uses low lane");
    acc(16'h2001, 16'h5A00, 1, 1, 0, 0, 3'b000, "R4 odd byte low lane differs");
    set_arm(0);
  endtask

  task automatic t_dir;
    wr(2, 1, 8'h30); wr(2, 2, 8'h00); wr(2, 0, 8'h06);
    set_arm(1);
    acc(16'h3000, 0, 1, 0, 0, 0, 3'b100, "R5 read qualifier read");
    acc(16'h3000, 0, 0, 0, 0, 0, 3'b000, "R5 read qualifier write");
    set_arm(0);
  endtask

  task automatic t_size;
    wr(2, 0, 8'h18);
    rd(2, 0, 8'h18, "R11 ctrl readback");
    set_arm(1);
    acc(16'h3000, 0, 0, 1, 0, 0, 3'b100, "R6 byte qualifier byte");
    acc(16'h3000, 0, 0, 0, 0, 0, 3'b000, "R6 byte qualifier word");
    set_arm(0);
  endtask

  task automatic t_tag;
    wr(1, 1, 8'h40); wr(1, 2, 8'h00); wr(1, 0, 8'h01);
    set_arm(1);
    acc(16'h4000, 0, 1, 0, 1, 3, 3'b000, "R7 fetch marks silently");
    ex(2, 0, 3'b000, "R7 wrong tag");
    ex(3, 0, 3'b010, "R7 tag executes");
    ex(3, 0, 3'b000, "R7 mark consumed");
    acc(16'h4000, 0, 1, 0, 0, 4, 3'b000, "R7 non-fetch hit");
    ex(4, 0, 3'b000, "R7 non-fetch records nothing");
    set_arm(0);
    wr(0, 0, 8'h01);
    set_arm(1);
    acc(16'h2001, 16'hFFFF, 1, 0, 1, 9, 3'b000, "R7 ch0 tagged fetch");
    ex(9, 0, 3'b001, "R7 data ignored in tag mode");
    set_arm(0);
  endtask

  task automatic t_flush;
    set_arm(1);
    acc(16'h4000, 0, 1, 0, 1, 5, 3'b000, "R8 mark");
    ex(5, 1, 3'b000, "R8 flush with exec same cycle");
    ex(5, 0, 3'b000, "R8 mark gone after flush");
    acc(16'h4000, 0, 1, 0, 1, 6, 3'b000, "R8 mark again");
    ex(7, 1, 3'b000, "R8 flush only");
    ex(6, 0, 3'b000, "R8 flushed before exec");
    set_arm(0);
  endtask

  task automatic t_lock;
    set_arm(1);
    wr(2, 0, 8'h1F);
    rd(2, 0, 8'h18, "R9 write ignored while armed");
    set_arm(0);
    win_sel = 2'b01;
    wr(2, 0, 8'h00);
    rd(2, 0, 8'h00, "R9 read zero with window closed");
    win_sel = 2'b00;
    rd(2, 0, 8'h18, "R9 write ignored with window closed");
    rd(2, 7, 8'h00, "R11 unused offset reads 0");
  endtask

  task automatic t_disarm;
    acc(16'h3000, 0, 0, 1, 0, 0, 3'b000, "R10 no pulse disarmed");
    set_arm(1);
    acc(16'h4000, 0, 1, 0, 1, 2, 3'b000, "R10 mark");
    set_arm(0);
    set_arm(1);
    ex(2, 0, 3'b000, "R10 disarm drops mark");
    set_arm(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_addr();
    t_data();
    t_lane();
    t_dir();
    t_size();
    t_tag();
    t_flush();
    t_lock();
    t_disarm();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule